// File: doc/BRIEF.md
# Interrupt Aggregation Controller

This block gathers ten interrupt requests into one host interrupt line. Four of the requests are the summary lines of GPIO banks, which arrive already masked and cleared inside the banks. The other six come from peripheral blocks. Each cycle, every request is captured into a pending-status register. The host reads that register over a simple 16-bit register port to find out which source needs service.

A second register holds one enable bit for each peripheral source, where a set bit lets the source through, and a global enable bit. The GPIO summaries are always let through once the global enable is on. A third register holds a run bit for the controller. While that bit is clear, the status register stays zero and the host line stays low.

The host line is edge-signalled. It goes high when an enabled request is pending. It goes low when nothing enabled is pending. It also drops for exactly one cycle whenever a further enabled source becomes pending while the line is already high, so that every new request reaches the host as a fresh rising edge.

Top module: `irq_aggregator`

## Requirements
- R1: After a synchronous reset, the status, enable and run registers read 0 and `host_irq` is 0.
- R2: Reading address 0 returns the pending-status register, which holds the requests sampled at the previous clock edge. GPIO bank k sits in bit k (k = 0..3), peripheral source j sits in bit 4+j (j = 0..5), and bits 15:10 read 0.
- R3: A write to address 0 changes no register, so the status, enable and run registers read back as they would have without the write.
- R4: Address 1 is the enable register. Bits 9:4 (peripheral enables, 1 = enabled) and bit 15 (global enable) store the written data. All other bits read 0.
- R5: Address 2 bit 0 is the run bit, and its other bits read 0. While the run bit is 0, the status register reads 0 from the next edge and `host_irq` is 0 from the next edge. Address 3 reads 0.
- R6: With the run bit and the global enable set, a request on a GPIO summary line, or on an enabled peripheral line, raises `host_irq` two clock edges after the request appears.
- R7: A peripheral request whose enable bit is 0 still shows in the status register but does not affect `host_irq`.
- R8: While the global enable is 0, `host_irq` stays 0 whatever is pending.
- R9: `host_irq` falls one edge after the last enabled pending bit clears. A later request then produces a new rising edge.
- R10: If `host_irq` is high and a further enabled source becomes pending, `host_irq` is low for exactly one cycle and then high again. A newly pending source that is disabled causes no such gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe, takes effect on the clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| gpio_bank_irq | input | 4 | Summary request of each GPIO bank |
| periph_irq | input | 6 | Peripheral interrupt requests |
| host_irq | output | 1 | Edge-signalled interrupt to the host |

## Verification
The bench aims at the re-arm cases. It stacks a second enabled source onto a line that is already high, and it then stacks a disabled source onto the same high line. A design without the one-cycle gap would hide the second request from the host. A design that counted disabled sources would put a gap where none belongs. The bench also clears the last request and raises a new one to confirm a fresh edge follows. It drops the run bit while requests are still pending, where a design that ignored the run bit would keep the line high. It writes all ones to the status and enable addresses, where a design with a wrong write decode would corrupt the enables or the run bit.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    localparam int DATA_W       = 16;
    localparam int ADDR_W       = 2;
    localparam int N_GPIO_BANKS = 4;
    localparam int N_PERIPH     = 6;
    localparam int N_SRC        = N_GPIO_BANKS + N_PERIPH;
    localparam int GIE_POS      = 15;
    localparam int RUN_POS      = 0;

    typedef enum logic [ADDR_W-1:0] {
        RA_PEND   = 2'd0,
        RA_ENABLE = 2'd1,
        RA_RUN    = 2'd2,
        RA_SPARE  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic                gie;
        logic [N_PERIPH-1:0] periph_en;
    } enable_t;

    function automatic logic [DATA_W-1:0] enable_to_word(enable_t e);
        logic [DATA_W-1:0] w;
        w = '0;
        w[GIE_POS] = e.gie;
        w[N_GPIO_BANKS +: N_PERIPH] = e.periph_en;
        return w;
    endfunction

    function automatic enable_t word_to_enable(logic [DATA_W-1:0] w);
        enable_t e;
        e.gie       = w[GIE_POS];
        e.periph_en = w[N_GPIO_BANKS +: N_PERIPH];
        return e;
    endfunction

    // GPIO summaries are always enabled; peripheral bits follow their enables;
    // everything is gated by the global enable.
    function automatic logic [N_SRC-1:0] source_gate(enable_t e);
        return {e.periph_en, {N_GPIO_BANKS{1'b1}}} & {N_SRC{e.gie}};
    endfunction

endpackage

// File: rtl/irqagg_status.sv
module irqagg_status
    import irqagg_pkg::*;
#(
    parameter int NB = N_GPIO_BANKS,
    parameter int NP = N_PERIPH,
    localparam int NS = NB + NP
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [NB-1:0] gpio_req,
    input  logic [NP-1:0] periph_req,
    output logic [NS-1:0] pend_q
);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pend_q <= '0;
        end else begin
            pend_q <= {periph_req, gpio_req};
        end
    end

    // R2
    pend_capture_chk: assert property (@(posedge clk) disable iff (rst)
        run |=> pend_q == $past({periph_req, gpio_req}));

    // R5
    pend_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> pend_q == '0);

endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs
    import irqagg_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NS = N_SRC
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    bus_addr,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    input  logic [NS-1:0] pend_q,
    output logic [DW-1:0] bus_rdata,
    output enable_t       en_q,
    output logic          run_q
);

    reg_addr_e sel;
    assign sel = reg_addr_e'(bus_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            run_q <= 1'b0;
        end else if (bus_wr) begin
            case (sel)
                RA_ENABLE: en_q  <= word_to_enable(bus_wdata);
                RA_RUN:    run_q <= bus_wdata[RUN_POS];
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            RA_PEND:   bus_rdata[NS-1:0] = pend_q;
            RA_ENABLE: bus_rdata = enable_to_word(en_q);
            RA_RUN:    bus_rdata[RUN_POS] = run_q;
            default:   bus_rdata = '0;
        endcase
    end

    // R4
    enable_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd1) |=>
            enable_to_word(en_q) == ($past(bus_wdata) & enable_to_word('1)));

    // R3
    pend_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd0) |=> ($stable(en_q) && $stable(run_q)));

endmodule

// File: rtl/irqagg_edge.sv
module irqagg_edge #(
    parameter int NS = irqagg_pkg::N_SRC
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NS-1:0] act,
    output logic          host_irq
);

    logic [NS-1:0] prev_q;
    logic [NS-1:0] fresh;
    logic          irq_q;
    logic          irq_d;

    assign fresh = act & ~prev_q;
    // A fresh source while already high forces one low cycle so it re-edges.
    assign irq_d = (|act) & ~(irq_q & (|fresh));

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            prev_q <= act;
            irq_q  <= irq_d;
        end
    end

    assign host_irq = irq_q;

    // R9
    all_clear_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (act == '0) |=> !host_irq);

    // R10
    rearm_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (host_irq && (act & ~prev_q) != '0) |=> !host_irq);

    // R10
    gap_recovers_chk: assert property (@(posedge clk) disable iff (rst)
        (!host_irq && act != '0 && act == prev_q) |=> host_irq);

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irqagg_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_wr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    input  logic [N_GPIO_BANKS-1:0] gpio_bank_irq,
    input  logic [N_PERIPH-1:0]     periph_irq,
    output logic                    host_irq
);

    logic [N_SRC-1:0] pend_q;
    logic [N_SRC-1:0] act;
    enable_t          en_q;
    logic             run_q;

    irqagg_regs #(.DW(DATA_W), .NS(N_SRC)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .pend_q    (pend_q),
        .bus_rdata (bus_rdata),
        .en_q      (en_q),
        .run_q     (run_q)
    );

    irqagg_status #(.NB(N_GPIO_BANKS), .NP(N_PERIPH)) status_i (
        .clk        (clk),
        .rst        (rst),
        .run        (run_q),
        .gpio_req   (gpio_bank_irq),
        .periph_req (periph_irq),
        .pend_q     (pend_q)
    );

    assign act = pend_q & source_gate(en_q) & {N_SRC{run_q}};

    irqagg_edge #(.NS(N_SRC)) edge_i (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .host_irq (host_irq)
    );

    // R8
    gie_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !en_q.gie |=> !host_irq);

    // R5
    run_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !run_q |=> !host_irq);

    // R7
    disabled_periph_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q[N_SRC-1:N_GPIO_BANKS] & ~en_q.periph_en) != '0 &&
        (pend_q[N_SRC-1:N_GPIO_BANKS] & en_q.periph_en) == '0 &&
        pend_q[N_GPIO_BANKS-1:0] == '0 |=> !host_irq);

endmodule

// File: tb/irq_aggregator_tb_top.sv
module irq_aggregator_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  bus_addr;
    logic        bus_wr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic [3:0]  gpio_bank_irq;
    logic [5:0]  periph_irq;
    logic        host_irq;

    always #5 clk = ~clk;

    irq_aggregator dut_i (
        .clk           (clk),
        .rst           (rst),
        .bus_addr      (bus_addr),
        .bus_wr        (bus_wr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .gpio_bank_irq (gpio_bank_irq),
        .periph_irq    (periph_irq),
        .host_irq      (host_irq)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    started = 1'b0;
    bit    done = 1'b0;

    // behavioural reference state
    logic [9:0]  m_pend, m_prev, m_act, m_new;
    logic [15:0] m_en;
    logic        m_run, m_irq;

    always @(posedge clk) begin
        if (rst) begin
            m_pend = '0; m_prev = '0; m_en = '0; m_run = 1'b0; m_irq = 1'b0;
        end else begin
            m_act  = m_run ? (m_pend & {m_en[9:4], 4'hF} & {10{m_en[15]}}) : 10'h0;
            m_new  = m_act & ~m_prev;
            m_irq  = (m_act != 0) && !(m_irq && m_new != 0);
            m_prev = m_act;
            m_pend = m_run ? {periph_irq, gpio_bank_irq} : 10'h0;
            if (bus_wr && bus_addr == 2'd1) m_en = bus_wdata & 16'h83F0;
            if (bus_wr && bus_addr == 2'd2) m_run = bus_wdata[0];
        end
        started = 1'b1;
    end

    function automatic logic [15:0] model_read(logic [1:0] a);
        case (a)
            2'd0:    return {6'h0, m_pend};
            2'd1:    return m_en;
            2'd2:    return {15'h0, m_run};
            default: return 16'h0;
        endcase
    endfunction

    task automatic check(string what, logic [15:0] actual, logic [15:0] expected);
        n_chk++;
        if (actual !== expected) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, actual, expected);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (started && !done) begin
            check("model host_irq", {15'h0, host_irq}, {15'h0, m_irq});
            check("model rdata", bus_rdata, model_read(bus_addr));
        end
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        cyc(1);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(logic [1:0] a, logic [15:0] exp);
        bus_addr = a;
        #1;
        check("read", bus_rdata, exp);
    endtask

    task automatic irq_chk(logic exp);
        check("host_irq", {15'h0, host_irq}, {15'h0, exp});
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; bus_addr = 2'd0; bus_wr = 1'b0; bus_wdata = '0;
        gpio_bank_irq = '0; periph_irq = '0;
        cyc(3);
        rst = 1'b0;

        cur_req = "R1";
        rd_chk(2'd0, 16'h0); rd_chk(2'd1, 16'h0); rd_chk(2'd2, 16'h0); irq_chk(1'b0);

        cur_req = "R5";
        wr(2'd1, 16'h83F0);
        gpio_bank_irq = 4'hF; periph_irq = 6'h3F;
        cyc(3);
        rd_chk(2'd0, 16'h0); irq_chk(1'b0); rd_chk(2'd3, 16'h0);
        wr(2'd2, 16'hFFFF);
        rd_chk(2'd2, 16'h0001);

        cur_req = "R6";
        cyc(2);
        irq_chk(1'b1);

        cur_req = "R2";
        gpio_bank_irq = 4'b0101; periph_irq = 6'b100110;
        cyc(1);
        rd_chk(2'd0, 16'h0265);
        gpio_bank_irq = 4'b1010; periph_irq = 6'b011001;
        cyc(1);
        rd_chk(2'd0, 16'h019A);

        cur_req = "R3";
        wr(2'd0, 16'hFFFF);
        rd_chk(2'd0, 16'h019A); rd_chk(2'd1, 16'h83F0); rd_chk(2'd2, 16'h0001);

        cur_req = "R4";
        wr(2'd1, 16'hFFFF);
        rd_chk(2'd1, 16'h83F0);
        wr(2'd1, 16'h7C0F);
        rd_chk(2'd1, 16'h0000);

        cur_req = "R7";
        wr(2'd1, 16'h8000);
        gpio_bank_irq = 4'h0; periph_irq = 6'h3F;
        cyc(3);
        irq_chk(1'b0); rd_chk(2'd0, 16'h03F0);

        cur_req = "R6";
        gpio_bank_irq = 4'b0100;
        cyc(2);
        irq_chk(1'b1);
        cur_req = "R9";
        gpio_bank_irq = 4'b0000;
        cyc(2);
        irq_chk(1'b0);

        cur_req = "R8";
        wr(2'd1, 16'h03F0);
        gpio_bank_irq = 4'hF;
        cyc(3);
        irq_chk(1'b0);

        cur_req = "R9";
        wr(2'd1, 16'h8010);
        gpio_bank_irq = 4'h0; periph_irq = 6'h00;
        cyc(3);
        irq_chk(1'b0);
        periph_irq = 6'b000001;
        cyc(2);
        irq_chk(1'b1);
        cyc(3);
        irq_chk(1'b1);

        cur_req = "R10";
        gpio_bank_irq = 4'b0001;
        cyc(2);
        irq_chk(1'b0);
        cyc(1);
        irq_chk(1'b1);

        cur_req = "R9";
        gpio_bank_irq = 4'b0000; periph_irq = 6'b000000;
        cyc(2);
        irq_chk(1'b0);
        periph_irq = 6'b000001;
        cyc(2);
        irq_chk(1'b1);

        cur_req = "R10";
        periph_irq = 6'b000011;
        cyc(2);
        irq_chk(1'b1);
        cyc(1);
        irq_chk(1'b1);

        cur_req = "R5";
        wr(2'd2, 16'h0000);
        cyc(1);
        irq_chk(1'b0); rd_chk(2'd0, 16'h0000);
        cyc(2);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule